// File: doc/BRIEF.md
# Indirect-Pointer Serial Control Port

This block is the byte-wide host-side register port of a two-channel serial controller. A host reaches it through a narrow address: one address bit picks the control port or the data port, and the bit above it picks the channel. The data port moves single bytes: a write hands a transmit byte to the channel, and a read collects the last received byte. The control port reaches sixteen write registers and sixteen read registers per channel indirectly. The host first writes a pointer value, then accesses the register the pointer names, and the pointer falls back to zero on its own after that access.

A command code carried in the same byte as the pointer reaches the upper half of the register space. A dedicated write register holds channel reset commands that can clear one channel, the other, or both. The two baud time-constant bytes are visible again in the read space. The write registers of both channels are presented as a flat configuration bus for the line logic around the block. That logic also feeds received bytes in through a load strobe.

Top module: `serial_regport`

## Requirements
- R1: A control-port write while the channel pointer is 0 loads the pointer with data bits 2:0. When data bits 5:3 equal 3'b001, pointer bit 3 is also set, so that registers 8 to 15 become reachable. Any other code in bits 5:3 leaves pointer bit 3 clear.
- R2: A control-port write while the pointer is nonzero stores the byte in the write register the pointer names and returns the pointer to 0. Write register r of channel c appears on `wr_regs[c*128 + r*8 +: 8]`, and write register 0 holds no storage and reads 0 there.
- R3: `rdata` presents the read register named by the pointer of the addressed channel while the control port is addressed. A control-port read returns the pointer to 0.
- R4: Write register 9 is never stored. In a byte written to it, bit 6 resets channel 0, bit 7 resets channel 1, and both bits reset both channels. With both bits at 0 the write has no effect apart from clearing the pointer. A reset takes priority over any other update of that channel in the same cycle.
- R5: After `rst_n` or a reset command the channel holds these values. Write registers 4, 9, 11, 14 and 15 hold 0x04, 0xC0, 0x08, 0x30 and 0xF8. Read register 0 reads 0x44, read register 1 reads 0x07, the pointer is 0, and every other register and byte is 0.
- R6: Read registers 12 and 13 return the contents of write registers 12 and 13.
- R7: A data-port write stores the byte on `tx_data[c*8 +: 8]`. It also sets read register 0 bit 2 (transmit empty) and read register 1 bit 0 (all sent).
- R8: A pulse on `rx_load[c]` stores `rx_byte` as the receive byte and sets read register 0 bit 0. While the data port is addressed, `rdata` presents the receive byte, and a data-port read clears bit 0 unless a load arrives in the same cycle.
- R9: Read registers other than 0, 1, 12 and 13 read 0.
- R10: The address bit at position SHIFT selects control (0) or data (1), and the bit at SHIFT+1 selects the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | SHIFT+2 | Bit SHIFT picks control/data, bit SHIFT+1 picks the channel |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, ignored while `wr_en` is high |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Combinational read byte for the addressed port |
| rx_load | input | 2 | Per-channel receive load strobe |
| rx_byte | input | 8 | Received byte for `rx_load` |
| tx_data | output | 16 | Transmit byte per channel |
| wr_regs | output | 256 | All write registers of both channels |

## Verification
The properties assume that the host gives a write and a read in the same cycle only with the write winning. They also assume that address bits above SHIFT+1 do not exist, so every address maps to exactly one channel and one port. The stimulus applies one strobe per cycle, drives the address and data at the falling edge and holds them across exactly one rising edge. A receive load coincides with a data read only in the one case built to show that the load wins.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;

    localparam int DW      = 8;
    localparam int NREG    = 16;
    localparam int PW      = $clog2(NREG);
    localparam int NCH     = 2;

    // register numbers whose function the block decodes
    localparam logic [PW-1:0] REG_RESET = 4'd9;
    localparam logic [PW-1:0] REG_TC_LO = 4'd12;
    localparam logic [PW-1:0] REG_TC_HI = 4'd13;
    localparam logic [PW-1:0] REG_STAT  = 4'd0;
    localparam logic [PW-1:0] REG_DONE  = 4'd1;

    localparam logic [2:0] CMD_UPPER = 3'b001;

    // status and completion bit positions
    localparam int ST_RX_AVAIL = 0;
    localparam int ST_TX_EMPTY = 2;
    localparam int DN_ALL_SENT = 0;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic [PW-1:0]             ptr;
        logic [NREG-1:0][DW-1:0]   wreg;
        byte_t                     stat;
        byte_t                     done;
        byte_t                     tx;
        byte_t                     rx;
    } chan_t;

    function automatic chan_t chan_default();
        chan_t c;
        c         = '0;
        c.wreg[4]  = 8'h04;
        c.wreg[9]  = 8'hC0;
        c.wreg[11] = 8'h08;
        c.wreg[14] = 8'h30;
        c.wreg[15] = 8'hF8;
        c.stat     = 8'h44;
        c.done     = 8'h07;
        return c;
    endfunction

endpackage

// File: rtl/serial_regport_decode.sv
module serial_regport_decode
    import serial_regport_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int AW   = SHIFT + 2
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic           chan_sel,
    output logic           is_data,
    output logic [NCH-1:0] wr_ctrl,
    output logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] rd_ctrl,
    output logic [NCH-1:0] rd_data
);

    logic rd_eff;

    always_comb begin
        chan_sel = addr[SHIFT+1];
        is_data  = addr[SHIFT];
        rd_eff   = rd_en & ~wr_en;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_strobe
        logic hit;
        always_comb begin
            hit        = (chan_sel == 1'(c));
            wr_ctrl[c] = hit & wr_en  & ~is_data;
            wr_data[c] = hit & wr_en  &  is_data;
            rd_ctrl[c] = hit & rd_eff & ~is_data;
            rd_data[c] = hit & rd_eff &  is_data;
        end
    end

endmodule

// File: rtl/serial_regport_chan.sv
module serial_regport_chan
    import serial_regport_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_ctrl,
    input  logic                    wr_data,
    input  logic                    rd_ctrl,
    input  logic                    rd_data,
    input  byte_t                   wdata,
    input  logic                    chan_rst,
    input  logic                    rx_load,
    input  byte_t                   rx_byte,
    output logic [PW-1:0]           ptr,
    output logic [NREG-1:0][DW-1:0] wregs,
    output byte_t                   tx,
    output byte_t                   rx,
    output byte_t                   rd_reg
);

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (chan_rst) begin
            st_d = chan_default();
        end else begin
            if (wr_ctrl) begin
                if (st_q.ptr == '0) begin
                    st_d.ptr = {(wdata[5:3] == CMD_UPPER), wdata[2:0]};
                end else begin
                    if (st_q.ptr != REG_RESET) begin
                        st_d.wreg[st_q.ptr] = wdata;
                    end
                    st_d.ptr = '0;
                end
            end
            if (rd_ctrl) begin
                st_d.ptr = '0;
            end
            if (wr_data) begin
                st_d.tx                = wdata;
                st_d.stat[ST_TX_EMPTY] = 1'b1;
                st_d.done[DN_ALL_SENT] = 1'b1;
            end
            if (rd_data) begin
                st_d.stat[ST_RX_AVAIL] = 1'b0;
            end
            if (rx_load) begin
                st_d.stat[ST_RX_AVAIL] = 1'b1;
                st_d.rx                = rx_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= chan_default();
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.ptr)
            REG_STAT:             rd_reg = st_q.stat;
            REG_DONE:             rd_reg = st_q.done;
            REG_TC_LO, REG_TC_HI: rd_reg = st_q.wreg[st_q.ptr];
            default:              rd_reg = '0;
        endcase
        ptr   = st_q.ptr;
        wregs = st_q.wreg;
        tx    = st_q.tx;
        rx    = st_q.rx;
    end

endmodule

// File: rtl/serial_regport.sv
module serial_regport
    import serial_regport_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int AW   = SHIFT + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          addr,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic [NCH-1:0]         rx_load,
    input  logic [DW-1:0]          rx_byte,
    output logic [NCH*DW-1:0]      tx_data,
    output logic [NCH*NREG*DW-1:0] wr_regs
);

    logic                  chan_sel;
    logic                  is_data;
    logic [NCH-1:0]        wr_ctrl, wr_data, rd_ctrl, rd_data;
    logic [NCH-1:0][PW-1:0] ptr_all;
    logic [NCH-1:0][DW-1:0] rd_all, rx_all;
    logic [NCH-1:0]        chan_rst;
    logic                  rst_cmd;

    serial_regport_decode #(.SHIFT(SHIFT)) u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .chan_sel (chan_sel),
        .is_data  (is_data),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .rd_ctrl  (rd_ctrl),
        .rd_data  (rd_data)
    );

    // a reset command is a control write aimed at register 9
    always_comb begin
        rst_cmd  = wr_ctrl[chan_sel] && (ptr_all[chan_sel] == REG_RESET);
        chan_rst = rst_cmd ? wdata[7:6] : '0;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NREG-1:0][DW-1:0] wregs_c;
        byte_t                   tx_c;
        serial_regport_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_ctrl[c]),
            .wr_data  (wr_data[c]),
            .rd_ctrl  (rd_ctrl[c]),
            .rd_data  (rd_data[c]),
            .wdata    (wdata),
            .chan_rst (chan_rst[c]),
            .rx_load  (rx_load[c]),
            .rx_byte  (rx_byte),
            .ptr      (ptr_all[c]),
            .wregs    (wregs_c),
            .tx       (tx_c),
            .rx       (rx_all[c]),
            .rd_reg   (rd_all[c])
        );
        always_comb begin
            wr_regs[c*NREG*DW +: NREG*DW] = wregs_c;
            tx_data[c*DW +: DW]           = tx_c;
        end
    end

    always_comb begin
        rdata = is_data ? rx_all[chan_sel] : rd_all[chan_sel];
    end

endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
    parameter int SHIFT = 0,
    localparam int AW   = SHIFT + 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  addr,
    input logic           wr_en,
    input logic           rd_en,
    input logic [7:0]     wdata,
    input logic [15:0]    tx_data,
    input logic [255:0]   wr_regs,
    input logic [1:0][3:0] ptr_all
);

    logic ctl0, dat0;
    always_comb begin
        ctl0 = !addr[SHIFT] && !addr[SHIFT+1];
        dat0 =  addr[SHIFT] && !addr[SHIFT+1];
    end

    AST_PTR_UPPER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl0 && ptr_all[0] == 4'd0 && wdata[5:3] == 3'b001)
        |=> (ptr_all[0] == {1'b1, $past(wdata[2:0])})); // R1

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl0 && ptr_all[0] != 4'd0) |=> (ptr_all[0] == 4'd0)); // R2

    AST_PTR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ctl0) |=> (ptr_all[0] == 4'd0)); // R3

    AST_RESET_CMD_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[SHIFT] && ptr_all[addr[SHIFT+1]] == 4'd9 && wdata[6])
        |=> (wr_regs[4*8 +: 8] == 8'h04 && wr_regs[15*8 +: 8] == 8'hF8
             && ptr_all[0] == 4'd0)); // R4

    AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dat0) |=> (tx_data[7:0] == $past(wdata))); // R7

endmodule

bind serial_regport serial_regport_chk #(.SHIFT(SHIFT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .tx_data (tx_data),
    .wr_regs (wr_regs),
    .ptr_all (ptr_all)
);

// File: tb/sim_serial_regport.sv
`timescale 1ns/1ps
module sim_serial_regport;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [1:0]   rx_load = '0;
    logic [7:0]   rx_byte = '0;
    logic [15:0]  tx_data;
    logic [255:0] wr_regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mw [2][16];
    logic       rxav [2];

    always #2 clk = ~clk;

    serial_regport #(.SHIFT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_load(rx_load), .rx_byte(rx_byte),
        .tx_data(tx_data), .wr_regs(wr_regs)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic model_reset(input int c);
        for (int r = 0; r < 16; r++) mw[c][r] = 8'h00;
        mw[c][4] = 8'h04; mw[c][9] = 8'hC0; mw[c][11] = 8'h08;
        mw[c][14] = 8'h30; mw[c][15] = 8'hF8;
        rxav[c] = 1'b0;
    endtask

    function automatic logic [7:0] rexp(input int c, input int r);
        case (r)
            0:       return 8'h44 | {7'b0, rxav[c]};
            1:       return 8'h07;
            12, 13:  return mw[c][r];
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp_wregs(input string req);
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++)
                chk(req, wr_regs[c*128 + r*8 +: 8], (r == 0) ? 8'h00 : mw[c][r]);
    endtask

    task automatic wr(input logic ch, input logic dp, input logic [7:0] d);
        @(negedge clk);
        addr = {ch, dp}; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic ch, input logic dp, output logic [7:0] v);
        @(negedge clk);
        addr = {ch, dp}; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic setptr(input logic ch, input int r);
        logic [3:0] rr;
        rr = 4'(r);
        wr(ch, 1'b0, rr[3] ? {5'b00001, rr[2:0]} : {5'b00000, rr[2:0]});
    endtask

    task automatic regwrite(input logic ch, input int r, input logic [7:0] v);
        setptr(ch, r);
        wr(ch, 1'b0, v);
    endtask

    task automatic regread(input logic ch, input int r, output logic [7:0] v);
        if (r != 0) setptr(ch, r);
        rd(ch, 1'b0, v);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        model_reset(0); model_reset(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset state
        cmp_wregs("R5 reset wregs");
        for (int c = 0; c < 2; c++) begin
            regread(1'(c), 0, v); chk("R5 rreg0", v, 8'h44);
            regread(1'(c), 1, v); chk("R5 rreg1", v, 8'h07);
        end

        // R2 R1 R10: sweep every write register on both channels
        for (int c = 0; c < 2; c++) begin
            for (int r = 1; r < 16; r++) begin
                if (r != 9) begin
                    logic [7:0] val;
                    val = 8'(r * 13 + c * 100 + 7);
                    regwrite(1'(c), r, val);
                    mw[c][r] = val;
                    cmp_wregs("R2 R10 store");
                    // R3: pointer back to 0, a bare control read gives rreg0
                    rd(1'(c), 1'b0, v); chk("R2 R3 ptr cleared", v, rexp(c, 0));
                end
            end
        end

        // R3 R6 R9: sweep the read space
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++) begin
                regread(1'(c), r, v);
                chk("R3 R6 R9 read space", v, rexp(c, r));
            end

        // R1: a command code other than 001 does not reach the upper half
        wr(1'b0, 1'b0, 8'h2C);
        wr(1'b0, 1'b0, 8'h99);
        mw[0][4] = 8'h99;
        cmp_wregs("R1 other code stays low");

        // R4: code 00 changes nothing
        regwrite(1'b1, 9, 8'h00);
        cmp_wregs("R4 no-op reset write");
        rd(1'b1, 1'b0, v); chk("R4 ptr cleared", v, 8'h44);

        // R4 R5: channel-1 write resets channel 0 only
        regwrite(1'b1, 9, 8'h40);
        model_reset(0);
        cmp_wregs("R4 reset ch0 from ch1");

        // R4: channel-0 write resets channel 1 only
        regwrite(1'b0, 3, 8'h3A); mw[0][3] = 8'h3A;
        regwrite(1'b0, 9, 8'h80);
        model_reset(1);
        cmp_wregs("R4 reset ch1 from ch0");
        regread(1'b1, 12, v); chk("R5 R6 mirror after reset", v, 8'h00);

        // R4: both channels
        regwrite(1'b1, 13, 8'h5E); mw[1][13] = 8'h5E;
        regwrite(1'b1, 9, 8'hC0);
        model_reset(0); model_reset(1);
        cmp_wregs("R4 reset both");

        // R7: transmit bytes and status
        wr(1'b0, 1'b1, 8'hA5);
        chk("R7 tx ch0", tx_data[7:0], 8'hA5);
        wr(1'b1, 1'b1, 8'h3C);
        chk("R7 tx ch1", tx_data[15:8], 8'h3C);
        chk("R7 tx ch0 kept", tx_data[7:0], 8'hA5);
        regread(1'b1, 0, v); chk("R7 tx empty", v, 8'h44);
        regread(1'b1, 1, v); chk("R7 all sent", v, 8'h07);

        // R8: receive load then data read
        @(negedge clk); rx_load = 2'b10; rx_byte = 8'hC3;
        @(negedge clk); rx_load = 2'b00;
        rxav[1] = 1'b1;
        regread(1'b1, 0, v); chk("R8 rx avail set", v, 8'h45);
        regread(1'b0, 0, v); chk("R8 other channel clear", v, 8'h44);
        rd(1'b1, 1'b1, v); chk("R8 rx byte", v, 8'hC3);
        rxav[1] = 1'b0;
        regread(1'b1, 0, v); chk("R8 rx avail cleared", v, 8'h44);

        // R8: load in the same cycle as a data read wins
        @(negedge clk); rx_load = 2'b01; rx_byte = 8'h11;
        @(negedge clk); rx_load = 2'b00;
        @(negedge clk); addr = 2'b01; rd_en = 1'b1; rx_load = 2'b01; rx_byte = 8'h22;
        #1 v = rdata; chk("R8 old byte", v, 8'h11);
        @(negedge clk); rd_en = 1'b0; rx_load = 2'b00;
        regread(1'b0, 0, v); chk("R8 load beats clear", v, 8'h45);
        rd(1'b0, 1'b1, v); chk("R8 new byte", v, 8'h22);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule